// File: doc/BRIEF.md
# Calibration and Fast-Lock Charge-Pump Sequencer

This block orders what happens in a fractional-N synthesizer right after a new frequency word is committed. It runs on the phase-detector clock. A one-cycle start pulse, raised by the frequency write, launches a timed sequence. The first phase is a VCO calibration window. During this window the charge pump is tri-stated and the VCO tune line is switched to an internal reference. The length of the window follows from a 4-bit precision code.

If fast lock is enabled, a high-current window follows. Its length follows from a 4-bit timer code, and the pump runs on the fast-lock current code. The sequence then settles in normal operation on the normal current code.

The downstream analog drivers use the block's outputs: the active 3-bit current code, a tri-state enable, a tune-select line and a 2-bit phase indicator. A busy flag and a one-cycle done pulse tell the control logic when the loop is back in normal operation. The calibration band search itself lives elsewhere. This block only opens and closes its window.

Top module: `cal_lock_seq`

## Requirements
- R1: After synchronous reset, phase reads idle (phase encoding: 0 idle, 1 calibrating, 2 fast lock, 3 normal). In this state pump_hiz=0, tune_ref_sel=0, busy=0, done=0, and cp_code equals cp_norm_code.
- R2: A start pulse sampled at a clock edge puts the block in the calibrating phase from that edge on. With a precision code c in 1..11, that phase lasts (6 + 2^c)·8 + 3 clock cycles.
- R3: A precision code of 0 gives the calibration length of code 1. A code above 11 gives the length of code 11.
- R4: Throughout the calibrating phase, pump_hiz=1 and tune_ref_sel=1.
- R5: With fast_en=1 at start, calibration is followed by a fast-lock phase of 511 + F·512 cycles, where F is the 4-bit timer code. During this phase cp_code equals cp_fast_code, tune_ref_sel=0 and the pump is not tri-stated unless it is forced.
- R6: With fast_en=0 at start, the block goes straight from calibrating to normal.
- R7: In idle and normal, cp_code follows cp_norm_code, including changes made while the block stays in that phase.
- R8: pump_hiz_force=1 makes pump_hiz=1 in every phase.
- R9: A start pulse during calibrating or fast lock restarts the sequence at the beginning of a full-length calibrating phase. The new length comes from the settings present at the new pulse.
- R10: busy is 1 exactly while calibrating or in fast lock. done is 1 only during the first cycle of the normal phase.
- R11: The precision code, fast_en and the timer code are captured at the start edge. Changing them later has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector rate clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frequency-write trigger pulse |
| cal_prec | input | 4 | Calibration precision code |
| fast_en | input | 1 | Enables the fast-lock phase |
| fast_tmr | input | 4 | Fast-lock timer code |
| cp_norm_code | input | 3 | Pump current code for normal operation |
| cp_fast_code | input | 3 | Pump current code for fast lock |
| pump_hiz_force | input | 1 | Forces the pump output to tri-state |
| cp_code | output | 3 | Active pump current code |
| pump_hiz | output | 1 | Pump tri-state enable |
| tune_ref_sel | output | 1 | 1: tune line on internal reference |
| phase | output | 2 | Current phase, encoded as in R1 |
| busy | output | 1 | Calibrating or fast lock in progress |
| done | output | 1 | One-cycle pulse on entering normal |

## Verification
The sequence is run under several settings. The precision codes cover both ends of the legal range, a mid value and the two clamped illegal values, so a wrong exponent, a missing +3 overhead and a missing clamp each give a different measured length. The fast-lock setting is tried both on and off, with timer codes 0, 1, 2 and 15. This separates a dropped 512 step, an off-by-one in the 511 base and a skipped phase. After every start the settings are scrambled, so any configuration read live instead of captured shows up as a wrong length. Directed runs restart the sequence in the middle of calibration and of fast lock, apply the force input in the idle, fast-lock and normal phases, and change the normal current code during the normal phase.

// File: rtl/cls_pkg.sv
package cls_pkg;

    localparam int PREC_W   = 4;
    localparam int TMR_W    = 4;
    localparam int CP_W     = 3;
    localparam int PREC_MIN = 1;
    localparam int PREC_MAX = 11;
    localparam int CAL_OVH  = 3;
    localparam int CAL_BASE = 6;
    localparam int CAL_MUL  = 8;
    localparam int FAST_BASE = 511;
    localparam int FAST_STEP = 512;
    localparam int CAL_MAXLEN  = (CAL_BASE + (1 << PREC_MAX)) * CAL_MUL + CAL_OVH;
    localparam int FAST_MAXLEN = FAST_BASE + ((1 << TMR_W) - 1) * FAST_STEP;
    localparam int MAXLEN = (CAL_MAXLEN > FAST_MAXLEN) ? CAL_MAXLEN : FAST_MAXLEN;
    localparam int CNT_W  = $clog2(MAXLEN + 1);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CAL  = 2'd1,
        PH_FAST = 2'd2,
        PH_NORM = 2'd3
    } phase_t;

    typedef struct packed {
        logic             fast_en;
        logic [TMR_W-1:0] fast_tmr;
    } fast_cfg_t;

    function automatic int clamp_prec(input logic [PREC_W-1:0] c);
        int v;
        v = int'(c);
        if (v < PREC_MIN) v = PREC_MIN;
        if (v > PREC_MAX) v = PREC_MAX;
        return v;
    endfunction

    function automatic logic [CNT_W-1:0] cal_len(input logic [PREC_W-1:0] c);
        int n;
        n = (CAL_BASE + (1 << clamp_prec(c))) * CAL_MUL + CAL_OVH;
        return CNT_W'(n);
    endfunction

    function automatic logic [CNT_W-1:0] fast_len(input logic [TMR_W-1:0] f);
        int n;
        n = FAST_BASE + int'(f) * FAST_STEP;
        return CNT_W'(n);
    endfunction

endpackage

// File: rtl/cls_timer.sv
module cls_timer #(
    parameter int W = cls_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R2
    timer_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/cls_ctrl.sv
module cls_ctrl
    import cls_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PREC_W-1:0] cal_prec,
    input  fast_cfg_t         cfg_in,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output phase_t            phase,
    output logic              busy,
    output logic              done
);
    fast_cfg_t cfg_q;
    phase_t    nxt;

    always_comb begin
        nxt      = phase;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (start) begin
            nxt      = PH_CAL;
            tmr_load = 1'b1;
            tmr_val  = cal_len(cal_prec) - 1'b1;
        end else if (tmr_zero) begin
            unique case (phase)
                PH_CAL: begin
                    if (cfg_q.fast_en) begin
                        nxt      = PH_FAST;
                        tmr_load = 1'b1;
                        tmr_val  = fast_len(cfg_q.fast_tmr) - 1'b1;
                    end else begin
                        nxt = PH_NORM;
                    end
                end
                PH_FAST: nxt = PH_NORM;
                default: nxt = phase;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cfg_q <= '0;
            done  <= 1'b0;
        end else begin
            phase <= nxt;
            if (start) cfg_q <= cfg_in;
            done  <= (nxt == PH_NORM) && (phase != PH_NORM);
        end
    end

    assign busy = (phase == PH_CAL) || (phase == PH_FAST);

    // R9
    start_to_cal_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (phase == PH_CAL));
    // R2
    idle_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |=> (phase == PH_IDLE || phase == PH_CAL));
    // R6
    no_fast_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CAL && !cfg_q.fast_en && !start) |=> (phase != PH_FAST));
endmodule

// File: rtl/cls_drive.sv
module cls_drive
    import cls_pkg::*;
(
    input  phase_t          phase,
    input  logic [CP_W-1:0] cp_norm_code,
    input  logic [CP_W-1:0] cp_fast_code,
    input  logic            pump_hiz_force,
    output logic [CP_W-1:0] cp_code,
    output logic            pump_hiz,
    output logic            tune_ref_sel
);
    always_comb begin
        cp_code      = cp_norm_code;
        pump_hiz     = pump_hiz_force;
        tune_ref_sel = 1'b0;
        unique case (phase)
            PH_CAL: begin
                pump_hiz     = 1'b1;
                tune_ref_sel = 1'b1;
            end
            PH_FAST: cp_code = cp_fast_code;
            default: ;
        endcase
    end
endmodule

// File: rtl/cal_lock_seq.sv
module cal_lock_seq
    import cls_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PREC_W-1:0] cal_prec,
    input  logic              fast_en,
    input  logic [TMR_W-1:0]  fast_tmr,
    input  logic [CP_W-1:0]   cp_norm_code,
    input  logic [CP_W-1:0]   cp_fast_code,
    input  logic              pump_hiz_force,
    output logic [CP_W-1:0]   cp_code,
    output logic              pump_hiz,
    output logic              tune_ref_sel,
    output logic [1:0]        phase,
    output logic              busy,
    output logic              done
);
    phase_t           ph;
    logic             tmr_load;
    logic             tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    fast_cfg_t        cfg;

    assign cfg.fast_en  = fast_en;
    assign cfg.fast_tmr = fast_tmr;

    cls_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cal_prec (cal_prec),
        .cfg_in   (cfg),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .phase    (ph),
        .busy     (busy),
        .done     (done)
    );

    cls_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    cls_drive u_drive (
        .phase          (ph),
        .cp_norm_code   (cp_norm_code),
        .cp_fast_code   (cp_fast_code),
        .pump_hiz_force (pump_hiz_force),
        .cp_code        (cp_code),
        .pump_hiz       (pump_hiz),
        .tune_ref_sel   (tune_ref_sel)
    );

    assign phase = ph;

    // R4
    cal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_CAL) |-> (pump_hiz && tune_ref_sel));
    // R5
    fast_code_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_FAST) |-> (cp_code == cp_fast_code && !tune_ref_sel));
    // R8
    force_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        pump_hiz_force |-> pump_hiz);
    // R10
    done_norm_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (ph == PH_NORM && !busy));
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/cal_lock_seq_test.sv
module cal_lock_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] cal_prec = '0;
    logic       fast_en = 1'b0;
    logic [3:0] fast_tmr = '0;
    logic [2:0] cp_norm_code = 3'd2;
    logic [2:0] cp_fast_code = 3'd6;
    logic       pump_hiz_force = 1'b0;
    logic [2:0] cp_code;
    logic       pump_hiz, tune_ref_sel, busy, done;
    logic [1:0] phase;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    cal_lock_seq uut (
        .clk(clk), .rst(rst), .start(start), .cal_prec(cal_prec),
        .fast_en(fast_en), .fast_tmr(fast_tmr), .cp_norm_code(cp_norm_code),
        .cp_fast_code(cp_fast_code), .pump_hiz_force(pump_hiz_force),
        .cp_code(cp_code), .pump_hiz(pump_hiz), .tune_ref_sel(tune_ref_sel),
        .phase(phase), .busy(busy), .done(done)
    );

    typedef struct packed {
        logic [3:0] prec;
        logic       fe;
        logic [3:0] tmr;
        logic [2:0] cpn;
        logic [2:0] cpf;
        int         cal_n;
        int         fast_n;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  1'b1, 4'd0,  3'd1, 3'd7, 67,    511},
        '{4'd0,  1'b1, 4'd1,  3'd2, 3'd5, 67,    1023},
        '{4'd3,  1'b0, 4'd5,  3'd3, 3'd6, 115,   0},
        '{4'd13, 1'b1, 4'd15, 3'd0, 3'd4, 16435, 8191},
        '{4'd11, 1'b0, 4'd0,  3'd4, 3'd1, 16435, 0},
        '{4'd4,  1'b1, 4'd2,  3'd5, 3'd3, 179,   1535}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [3:0] p, input logic fe, input logic [3:0] t);
        @(negedge clk);
        cal_prec = p; fast_en = fe; fast_tmr = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cal_prec = ~p; fast_en = ~fe; fast_tmr = ~t;
    endtask

    // counts cycles spent in phase ph; errs counts cycles with wrong outputs
    task automatic measure(input logic [1:0] ph, output int n, output int errs);
        n = 0; errs = 0;
        while (phase == ph && n < 20000) begin
            if (ph == 2'd1 && !(pump_hiz && tune_ref_sel && busy && !done)) errs++;
            if (ph == 2'd2 && !(cp_code == cp_fast_code && !pump_hiz && !tune_ref_sel && busy && !done)) errs++;
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int n, e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(phase == 2'd0, "R1 phase", phase, 0);
        chk(!pump_hiz && !tune_ref_sel && !busy && !done, "R1 flags",
            {pump_hiz, tune_ref_sel, busy, done}, 0);
        chk(cp_code == cp_norm_code, "R1 cp_code", cp_code, cp_norm_code);
        pump_hiz_force = 1'b1;
        #1 chk(pump_hiz == 1'b1, "R8 force idle", pump_hiz, 1);
        pump_hiz_force = 1'b0;

        // vector table: R2 R3 R4 R5 R6 R10 R11
        for (int i = 0; i < NV; i++) begin
            cp_norm_code = VECS[i].cpn;
            cp_fast_code = VECS[i].cpf;
            pulse_start(VECS[i].prec, VECS[i].fe, VECS[i].tmr);
            measure(2'd1, n, e);
            chk(n == VECS[i].cal_n, "R2/R3/R11 cal length", n, VECS[i].cal_n);
            chk(e == 0, "R4 cal outputs", e, 0);
            if (VECS[i].fe) begin
                chk(phase == 2'd2, "R5 enters fast", phase, 2);
                measure(2'd2, n, e);
                chk(n == VECS[i].fast_n, "R5/R11 fast length", n, VECS[i].fast_n);
                chk(e == 0, "R5 fast outputs", e, 0);
            end else begin
                chk(phase == 2'd3, "R6 skip fast", phase, 3);
            end
            chk(done == 1'b1 && busy == 1'b0, "R10 done at normal", {done, busy}, 2);
            chk(cp_code == VECS[i].cpn && !pump_hiz && !tune_ref_sel, "R7 normal outputs",
                cp_code, VECS[i].cpn);
            @(negedge clk);
            chk(done == 1'b0 && phase == 2'd3, "R10 done single", done, 0);
        end

        // R7 live normal code
        cp_norm_code = 3'd5;
        #1 chk(cp_code == 3'd5, "R7 live code", cp_code, 5);
        // R8 force in normal
        pump_hiz_force = 1'b1;
        #1 chk(pump_hiz == 1'b1, "R8 force normal", pump_hiz, 1);
        pump_hiz_force = 1'b0;

        // R9 restart during calibration
        cp_fast_code = 3'd7;
        pulse_start(4'd1, 1'b1, 4'd0);
        repeat (30) @(negedge clk);
        pulse_start(4'd3, 1'b1, 4'd0);
        measure(2'd1, n, e);
        chk(n == 115, "R9 restart in cal", n, 115);
        chk(phase == 2'd2, "R9 fast after restart", phase, 2);
        repeat (100) @(negedge clk);
        pump_hiz_force = 1'b1;
        #1 chk(pump_hiz == 1'b1 && phase == 2'd2, "R8 force fast", pump_hiz, 1);
        pump_hiz_force = 1'b0;
        // R9 restart during fast lock, new start without fast lock
        pulse_start(4'd1, 1'b0, 4'd3);
        measure(2'd1, n, e);
        chk(n == 67, "R9 restart in fast", n, 67);
        chk(phase == 2'd3 && done == 1'b1, "R6 restart no fast", phase, 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule